// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the external memory bus of an 8-bit controller core whose address and data share one multiplexed byte lane. It runs from the oscillator clock and divides each machine cycle into twelve clock slots. In every machine cycle it produces the address-latch pulses, the program-store read strobe for fetches from external code memory, the data read and write strobes for external data transfers, and the source choice for the high address byte. Before each machine cycle the core states what that cycle does: an external data transfer with a 16-bit pointer, one with an 8-bit pointer, a code-space table read, or an ordinary cycle. It also reports whether code runs from external memory and whether idle, power-down or emulation mode is active.

The block contains a one-bit control register that silences the address-latch output. While that bit is in force, the pin is handed to a weak pull-up, and the block signals this on a separate output. The bit is overridden for the whole cycle whenever the cycle is a transfer or table read, whenever a low-power or emulation mode is active, and whenever code runs externally. The block also filters the raw reset pin, so that a short pulse cannot reset the core.

There is no data stream at this boundary. Every pin is a plain level or strobe, so there is no valid/ready handshake and no back-pressure. The request levels are sampled once per machine cycle.

Top module: `xbus_strobe_seq`

## Requirements
- R1: `core_rst` goes high after `rst_pin` has been sampled high on 24 consecutive rising clock edges (two machine cycles). It goes low after the first edge that samples `rst_pin` low. While `core_rst` is high, `ale`, `ale_weak`, `psen`, `rd_stb` and `wr_stb` are low and the latch-disable bit is cleared.
- R2: A machine cycle is 12 clocks, in slots 0 to 11. Slot 0 is the first clock after `core_rst` falls. The request inputs sampled on the edge that ends slot 11 govern the whole of the next machine cycle. Reset leaves an ordinary cycle with internal code.
- R3: In a cycle that is not a data transfer, `ale` is high in slots 0, 1, 6 and 7. That gives two pulses per machine cycle, at one sixth of the clock rate.
- R4: In a data-transfer cycle (16-bit or 8-bit pointer), `ale` is high only in slots 0 and 1, and `psen` stays low for the whole cycle.
- R5: When the latched cycle runs code externally and is not a data transfer, `psen` is high in slots 2 to 5 and 8 to 11.
- R6: In a data-transfer cycle, a strobe is high in slots 6 to 11. It is `wr_stb` if `req_wr` was latched high and `rd_stb` otherwise. Neither strobe is ever high together with `psen` or with `ale`.
- R7: A write with `sfr_addr` = 0x8E loads bit 0 of `sfr_wdata` into the latch-disable bit. `sfr_rdata` returns that bit in bit 0 when `sfr_addr` = 0x8E and returns zero for any other address. Writes to other addresses leave the bit unchanged.
- R8: When the disable bit is set and nothing overrides it, `ale` stays low and `ale_weak` is high for the whole cycle.
- R9: A latched table read, either kind of data transfer, idle, power-down or emulation mode overrides the disable bit: `ale` follows R3/R4 and `ale_weak` is low.
- R10: When the latched cycle runs code externally, the disable bit has no effect: `ale` follows R3 and `ale_weak` is low.
- R11: In a 16-bit pointer transfer, `haddr_out` = `dptr_hi` and `haddr_src` = 2. In an 8-bit pointer transfer, `haddr_out` = `p2_latch` and `haddr_src` = 0. In other cycles with external code, `haddr_out` = `pc_hi` and `haddr_src` = 1. Otherwise `haddr_out` = `p2_latch` and `haddr_src` = 0.
- R12: When several cycle-kind requests are high together, the 16-bit transfer wins over the 8-bit transfer, and the 8-bit transfer wins over the table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one slot per period |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin, filtered by the block |
| ext_exec | input | 1 | Code for the next cycle comes from external memory |
| req_movc | input | 1 | Next cycle is a code-space table read |
| req_movx8 | input | 1 | Next cycle is a data transfer with an 8-bit pointer |
| req_movx16 | input | 1 | Next cycle is a data transfer with a 16-bit pointer |
| req_wr | input | 1 | The data transfer is a write |
| idle_mode | input | 1 | Idle mode active |
| pdown_mode | input | 1 | Power-down mode active |
| emu_mode | input | 1 | Emulation mode active |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data |
| dptr_hi | input | 8 | Upper byte of the 16-bit data pointer |
| pc_hi | input | 8 | Upper byte of the program counter |
| p2_latch | input | 8 | High-address port latch contents |
| core_rst | output | 1 | Filtered internal reset |
| ale | output | 1 | Address-latch pulse |
| ale_weak | output | 1 | Address-latch pin handed to the weak pull-up |
| psen | output | 1 | Program-store read strobe, active high |
| rd_stb | output | 1 | External data read strobe, active high |
| wr_stb | output | 1 | External data write strobe, active high |
| haddr_out | output | 8 | High address byte to drive |
| haddr_src | output | 2 | Source of haddr_out: 0 latch, 1 PC, 2 pointer |

## Verification
The assertions assume that the request levels are driven synchronously to `clk` and that `arst_n` is released in step with it. The stimulus changes every input one time unit after a rising edge. The bench never looks at the internal slot phase: each request pattern is held for two full machine cycles, so at least one cycle latches it completely. Conflicting request combinations and register writes that land in the middle of a cycle are applied on purpose. The reference model is therefore expected to follow the slot-11 sampling rule on its own.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_MOVC   = 2'd1,
    KIND_MOVX8  = 2'd2,
    KIND_MOVX16 = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    HSRC_LATCH = 2'd0,
    HSRC_PC    = 2'd1,
    HSRC_DPTR  = 2'd2
  } hsrc_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      wr;
    logic      ext;
    logic      idle;
    logic      pdown;
    logic      emu;
  } cyc_req_t;

  // Priority: wide pointer transfer, then narrow pointer transfer, then table read
  function automatic cyc_kind_e pick_kind(input logic m16, input logic m8, input logic mc);
    if (m16)     return KIND_MOVX16;
    else if (m8) return KIND_MOVX8;
    else if (mc) return KIND_MOVC;
    else         return KIND_NONE;
  endfunction

  function automatic logic is_data(input cyc_kind_e k);
    return (k == KIND_MOVX8) || (k == KIND_MOVX16);
  endfunction

endpackage

// File: rtl/xbs_rst_filter.sv
module xbs_rst_filter #(
  parameter int RUN_MAX = 24,
  parameter int RUN_W   = $clog2(RUN_MAX + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  output logic core_rst
);

  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)           run_q <= '0;
    else if (!rst_pin)     run_q <= '0;
    else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
  end

  assign core_rst = (run_q == RUN_TOP);

  // R1
  rst_needs_pin_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst) |-> $past(rst_pin));

  // R1
  rst_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_pin |=> !core_rst);

endmodule

// File: rtl/xbs_slot_ctr.sv
module xbs_slot_ctr
  import xbs_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int SLOT_W  = $clog2(CYC_LEN)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              core_rst,
  input  cyc_req_t          req_in,
  output logic [SLOT_W-1:0] slot,
  output cyc_req_t          req_q
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(CYC_LEN - 1);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      slot_q <= '0;
      req_q  <= '0;
    end else if (core_rst) begin
      slot_q <= '0;
      req_q  <= '0;
    end else if (slot_q == LAST) begin
      slot_q <= '0;
      req_q  <= req_in;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot = slot_q;

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_rst && slot_q == LAST) |=> (slot_q == '0));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_rst && slot_q != LAST && !$past(core_rst)) |=> $stable(req_q));

endmodule

// File: rtl/xbs_ale_ctl.sv
module xbs_ale_ctl
  import xbs_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              core_rst,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  cyc_req_t          req_q,
  output logic              dis_eff,
  output logic [DATA_W-1:0] sfr_rdata
);

  logic dis_q;
  logic hit;
  logic suspend;
  logic unused_wdata;

  assign hit          = (sfr_addr == REG_ADDR);
  assign unused_wdata = ^sfr_wdata[DATA_W-1:1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            dis_q <= 1'b0;
    else if (core_rst)      dis_q <= 1'b0;
    else if (sfr_wr && hit) dis_q <= sfr_wdata[0];
  end

  assign suspend   = (req_q.kind != KIND_NONE) | req_q.idle | req_q.pdown | req_q.emu;
  assign dis_eff   = dis_q & ~suspend & ~req_q.ext;
  assign sfr_rdata = hit ? {{(DATA_W-1){1'b0}}, dis_q} : '0;

  // R1
  dis_cleared_chk: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |=> !dis_q);

  // R7
  dis_keep_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_rst && !(sfr_wr && hit)) |=> $stable(dis_q));

endmodule

// File: rtl/xbs_strobe_gen.sv
module xbs_strobe_gen
  import xbs_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int SLOT_W  = $clog2(CYC_LEN),
  parameter int BYTE_W  = 8
) (
  input  logic              core_rst,
  input  logic [SLOT_W-1:0] slot,
  input  cyc_req_t          req_q,
  input  logic              dis_eff,
  input  logic [BYTE_W-1:0] dptr_hi,
  input  logic [BYTE_W-1:0] pc_hi,
  input  logic [BYTE_W-1:0] p2_latch,
  output logic              ale,
  output logic              ale_weak,
  output logic              psen,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] haddr_out,
  output logic [1:0]        haddr_src
);

  localparam int HALF   = CYC_LEN / 2;
  localparam int ALE_W  = CYC_LEN / 6;
  localparam int PSEN_W = HALF - ALE_W;
  localparam logic [SLOT_W-1:0] STB_LO = SLOT_W'(HALF);

  logic       data_cyc;
  logic [1:0] ale_hit;
  logic [1:0] psen_hit;
  logic       stb_win;
  hsrc_e      src;

  assign data_cyc = is_data(req_q.kind);

  // One address-latch window and one program-read window per half cycle
  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam logic [SLOT_W-1:0] ALE_LO  = SLOT_W'(g * HALF);
    localparam logic [SLOT_W-1:0] PSEN_LO = SLOT_W'(g * HALF + ALE_W);
    logic [SLOT_W-1:0] ale_off;
    logic [SLOT_W-1:0] psen_off;
    assign ale_off  = slot - ALE_LO;
    assign psen_off = slot - PSEN_LO;
    assign ale_hit[g]  = (ale_off < SLOT_W'(ALE_W)) & ((g == 0) ? 1'b1 : ~data_cyc);
    assign psen_hit[g] = (psen_off < SLOT_W'(PSEN_W)) & ~data_cyc & req_q.ext;
  end

  assign stb_win = data_cyc & ((slot - STB_LO) < SLOT_W'(HALF));

  always_comb begin
    ale      = 1'b0;
    ale_weak = 1'b0;
    psen     = 1'b0;
    rd_stb   = 1'b0;
    wr_stb   = 1'b0;
    if (!core_rst) begin
      ale      = (|ale_hit) & ~dis_eff;
      ale_weak = dis_eff;
      psen     = |psen_hit;
      rd_stb   = stb_win & ~req_q.wr;
      wr_stb   = stb_win & req_q.wr;
    end
  end

  always_comb begin
    unique case (req_q.kind)
      KIND_MOVX16: src = HSRC_DPTR;
      KIND_MOVX8:  src = HSRC_LATCH;
      default:     src = req_q.ext ? HSRC_PC : HSRC_LATCH;
    endcase
  end

  always_comb begin
    unique case (src)
      HSRC_DPTR: haddr_out = dptr_hi;
      HSRC_PC:   haddr_out = pc_hi;
      default:   haddr_out = p2_latch;
    endcase
  end

  assign haddr_src = src;

endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
  import xbs_pkg::*;
#(
  parameter int          CYC_LEN    = 12,
  parameter int          RST_CYCLES = 2,
  parameter int          ADDR_W     = 8,
  parameter int          BYTE_W     = 8,
  parameter logic [7:0]  DIS_ADDR   = 8'h8E
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              rst_pin,
  input  logic              ext_exec,
  input  logic              req_movc,
  input  logic              req_movx8,
  input  logic              req_movx16,
  input  logic              req_wr,
  input  logic              idle_mode,
  input  logic              pdown_mode,
  input  logic              emu_mode,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [BYTE_W-1:0] sfr_wdata,
  output logic [BYTE_W-1:0] sfr_rdata,
  input  logic [BYTE_W-1:0] dptr_hi,
  input  logic [BYTE_W-1:0] pc_hi,
  input  logic [BYTE_W-1:0] p2_latch,
  output logic              core_rst,
  output logic              ale,
  output logic              ale_weak,
  output logic              psen,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] haddr_out,
  output logic [1:0]        haddr_src
);

  localparam int SLOT_W  = $clog2(CYC_LEN);
  localparam int RUN_MAX = RST_CYCLES * CYC_LEN;

  cyc_req_t          req_in;
  cyc_req_t          req_q;
  logic [SLOT_W-1:0] slot;
  logic              dis_eff;

  always_comb begin
    req_in.kind  = pick_kind(req_movx16, req_movx8, req_movc);
    req_in.wr    = req_wr;
    req_in.ext   = ext_exec;
    req_in.idle  = idle_mode;
    req_in.pdown = pdown_mode;
    req_in.emu   = emu_mode;
  end

  xbs_rst_filter #(.RUN_MAX(RUN_MAX)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .core_rst(core_rst)
  );

  xbs_slot_ctr #(.CYC_LEN(CYC_LEN), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .arst_n(arst_n), .core_rst(core_rst),
    .req_in(req_in), .slot(slot), .req_q(req_q)
  );

  xbs_ale_ctl #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .REG_ADDR(ADDR_W'(DIS_ADDR))) u_ale (
    .clk(clk), .arst_n(arst_n), .core_rst(core_rst),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .req_q(req_q), .dis_eff(dis_eff), .sfr_rdata(sfr_rdata)
  );

  xbs_strobe_gen #(.CYC_LEN(CYC_LEN), .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)) u_stb (
    .core_rst(core_rst), .slot(slot), .req_q(req_q), .dis_eff(dis_eff),
    .dptr_hi(dptr_hi), .pc_hi(pc_hi), .p2_latch(p2_latch),
    .ale(ale), .ale_weak(ale_weak), .psen(psen),
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .haddr_out(haddr_out), .haddr_src(haddr_src)
  );

  // R6
  stb_vs_psen_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_stb || wr_stb) |-> !psen);

  // R6
  stb_vs_ale_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_stb || wr_stb) |-> !ale);

  // R6
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({rd_stb, wr_stb, psen}));

  // R8
  weak_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ale_weak |-> (!ale && !core_rst));

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    core_rst |-> !(ale || psen || rd_stb || wr_stb || ale_weak));

endmodule

// File: tb/sim_xbus_strobe_seq.sv
`timescale 1ns/1ps
module sim_xbus_strobe_seq;

  localparam int CYC     = 12;
  localparam int RUN_MAX = 24;
  localparam int WD_MAX  = 20000;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rst_pin = 1'b0;
  logic ext_exec = 1'b0, req_movc = 1'b0, req_movx8 = 1'b0, req_movx16 = 1'b0, req_wr = 1'b0;
  logic idle_mode = 1'b0, pdown_mode = 1'b0, emu_mode = 1'b0;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic [7:0] dptr_hi = 8'hA5, pc_hi = 8'h3C, p2_latch = 8'h77;
  logic [7:0] sfr_rdata, haddr_out;
  logic [1:0] haddr_src;
  logic core_rst, ale, ale_weak, psen, rd_stb, wr_stb;

  always #2 clk = ~clk;

  xbus_strobe_seq u0 (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .ext_exec(ext_exec),
    .req_movc(req_movc), .req_movx8(req_movx8), .req_movx16(req_movx16), .req_wr(req_wr),
    .idle_mode(idle_mode), .pdown_mode(pdown_mode), .emu_mode(emu_mode),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .dptr_hi(dptr_hi), .pc_hi(pc_hi), .p2_latch(p2_latch),
    .core_rst(core_rst), .ale(ale), .ale_weak(ale_weak), .psen(psen),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .haddr_out(haddr_out), .haddr_src(haddr_src)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_clk = 0;

  // Behavioural reference: integers only
  int m_run = 0, m_slot = 0, m_kind = 0;
  int m_wr = 0, m_ext = 0, m_idle = 0, m_pd = 0, m_emu = 0, m_dis = 0;

  always @(posedge clk) begin
    int was_rst;
    if (!arst_n) begin
      m_run = 0; m_slot = 0; m_kind = 0; m_wr = 0; m_ext = 0;
      m_idle = 0; m_pd = 0; m_emu = 0; m_dis = 0;
    end else begin
      was_rst = (m_run == RUN_MAX);
      if (rst_pin) m_run = (m_run < RUN_MAX) ? m_run + 1 : RUN_MAX;
      else m_run = 0;
      if (was_rst) begin
        m_slot = 0; m_kind = 0; m_wr = 0; m_ext = 0;
        m_idle = 0; m_pd = 0; m_emu = 0; m_dis = 0;
      end else begin
        if (m_slot == CYC - 1) begin
          // R12: priority of the kind requests
          m_kind = req_movx16 ? 3 : (req_movx8 ? 2 : (req_movc ? 1 : 0));
          m_wr = req_wr; m_ext = ext_exec;
          m_idle = idle_mode; m_pd = pdown_mode; m_emu = emu_mode;
          m_slot = 0;
        end else m_slot = m_slot + 1;  // R2
        if (sfr_wr && sfr_addr == 8'h8E) m_dis = sfr_wdata[0];
      end
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int rst_e, data, eff, e_ale, e_psen, e_stb, e_h, e_s;
    n_clk++;
    rst_e = (m_run == RUN_MAX);
    data  = (m_kind >= 2);
    eff   = m_dis && !(m_kind != 0 || m_idle || m_pd || m_emu) && !m_ext;
    e_ale = !rst_e && !eff && ((m_slot < 2) || (m_slot >= 6 && m_slot < 8 && !data));
    e_psen = !rst_e && m_ext && !data && ((m_slot >= 2 && m_slot < 6) || m_slot >= 8);
    e_stb = !rst_e && data && m_slot >= 6;
    if (m_kind == 3) begin e_h = dptr_hi; e_s = 2; end
    else if (m_kind != 2 && m_ext) begin e_h = pc_hi; e_s = 1; end
    else begin e_h = p2_latch; e_s = 0; end
    chk("R1", "core_rst", core_rst, rst_e);
    chk("R3", "ale", ale, e_ale);
    chk("R8", "ale_weak", ale_weak, !rst_e && eff);
    chk("R5", "psen", psen, e_psen);
    chk("R6", "rd_stb", rd_stb, e_stb && !m_wr);
    chk("R6", "wr_stb", wr_stb, e_stb && m_wr);
    chk("R7", "sfr_rdata", sfr_rdata, (sfr_addr == 8'h8E) ? m_dis : 0);
    chk("R11", "haddr_out", haddr_out, e_h);
    chk("R11", "haddr_src", haddr_src, e_s);
    if (n_clk > WD_MAX) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected<=%0d", n_clk, WD_MAX);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pat(input logic m16, input logic m8, input logic mc, input logic w,
                     input logic x, input logic id, input logic pd, input logic em);
    req_movx16 = m16; req_movx8 = m8; req_movc = mc; req_wr = w;
    ext_exec = x; idle_mode = id; pdown_mode = pd; emu_mode = em;
    tick(2 * CYC);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    tick(1);
    sfr_wr = 1'b0;
  endtask

  initial begin
    tick(3);
    arst_n = 1'b1;
    // R1: short pin pulse must not reset
    rst_pin = 1'b1; tick(RUN_MAX - 4); rst_pin = 1'b0; tick(3);
    // R1: full reset, two machine cycles plus margin
    rst_pin = 1'b1; tick(RUN_MAX + 6); rst_pin = 1'b0;
    // R3: plain internal cycles
    pat(0, 0, 0, 0, 0, 0, 0, 0);
    // R5 R11: external fetch
    pat(0, 0, 0, 0, 1, 0, 0, 0);
    // R4 R6 R11: data transfers, both pointer widths, read and write
    pat(1, 0, 0, 0, 1, 0, 0, 0);
    pat(1, 0, 0, 1, 1, 0, 0, 0);
    pat(0, 1, 0, 0, 0, 0, 0, 0);
    pat(0, 1, 0, 1, 1, 0, 0, 0);
    // R12: conflicting kind requests
    pat(1, 1, 1, 1, 0, 0, 0, 0);
    pat(0, 1, 1, 0, 1, 0, 0, 0);
    // R7 R8: set the disable bit, read it back
    sfr_addr = 8'h8E;
    reg_wr(8'h8E, 8'hFF);
    pat(0, 0, 0, 0, 0, 0, 0, 0);
    // R7: other address neither written nor read
    reg_wr(8'h8F, 8'h00);
    sfr_addr = 8'h8F; tick(3); sfr_addr = 8'h8E;
    pat(0, 0, 0, 0, 0, 0, 0, 0);
    // R9: every override
    pat(0, 0, 1, 0, 0, 0, 0, 0);
    pat(0, 1, 0, 0, 0, 0, 0, 0);
    pat(1, 0, 0, 1, 0, 0, 0, 0);
    pat(0, 0, 0, 0, 0, 1, 0, 0);
    pat(0, 0, 0, 0, 0, 0, 1, 0);
    pat(0, 0, 0, 0, 0, 0, 0, 1);
    // R10: external code ignores the bit
    pat(0, 0, 0, 0, 1, 0, 0, 0);
    pat(0, 0, 0, 0, 0, 0, 0, 0);
    // R7: clear by write with bit 0 low, then set again mid-cycle
    reg_wr(8'h8E, 8'hFE);
    pat(0, 0, 0, 0, 0, 0, 0, 0);
    tick(5); reg_wr(8'h8E, 8'h01);
    pat(0, 0, 0, 0, 0, 0, 0, 0);
    // R1: pin reset clears the bit
    rst_pin = 1'b1; tick(RUN_MAX + 2); rst_pin = 1'b0;
    pat(0, 0, 0, 0, 0, 0, 0, 0);
    pat(1, 0, 0, 0, 1, 0, 0, 0);
    tick(CYC);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule